// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block times the strobes of an 8-bit controller's multiplexed external memory bus. A free-running phase counter splits each machine cycle into twelve oscillator clocks. From that count the block produces the address latch strobe, the active-low code read strobe, a one-clock marker for the instant the low address byte must be captured, and the byte driven on the high-address port.

The core presents its requests for the coming machine cycle: an external data access, using either a 16-bit pointer or an 8-bit register-indirect address, or a code-table read. The block samples them once per machine cycle. Data cycles drop strobe pulses. A latch-suppress control bit silences the latch strobe except during data and code-table moves. That bit is overridden whenever code runs from external memory.

Top module: `sbs_strobe_seq`

## Requirements
- R1: Counting the clocks of a machine cycle 0 to 11 from the internal reset release, `ale` is high at counts 1, 2, 7 and 8 and low elsewhere. This gives two pulses every 12 clocks.
- R2: In a machine cycle flagged as an external data access, the `ale` pulse at counts 1 and 2 is omitted and the pulse at counts 7 and 8 is kept.
- R3: With `ale_off` = 1 and `ext_exec` = 0, `ale` stays low in every machine cycle that is neither a data access nor a code-table read. In a code-table read cycle both pulses appear.
- R4: With `ext_exec` = 1, `ale_off` has no effect on `ale`.
- R5: With `ext_exec` = 1 and no data access in the cycle, `psen_n` is low at counts 3 to 5 and 9 to 11. That is two assertions per cycle, never overlapping `ale`.
- R6: In an external data access cycle, both `psen_n` assertions of that cycle are skipped.
- R7: With `ext_exec` = 0, `psen_n` stays high.
- R8: At the start of each machine cycle, `p2_hi` loads one of three values. In a data cycle it takes `data_hi` when `req_wide` = 1 and `p2_sfr` when `req_wide` = 0. Otherwise it takes `code_hi` when `ext_exec` = 1 and `p2_sfr` when `ext_exec` = 0.
- R9: `lo_latch` is high for exactly one clock on each falling edge of `ale`, and at no other time.
- R10: While reset is asserted, the outputs are `ale` = 0, `psen_n` = 1, `lo_latch` = 0 and `p2_hi` = FFh. Requests are sampled only in the clock at count 11, and they apply to the machine cycle that follows.
- R11: `p2_hi` holds its value through counts 1 to 11 of each machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_exec | input | 1 | Code is fetched from external memory |
| ale_off | input | 1 | Latch-suppress control bit |
| req_xdata | input | 1 | Next machine cycle is an external data access |
| req_wide | input | 1 | Data access uses a 16-bit pointer |
| req_movc | input | 1 | Next machine cycle is a code-table read |
| p2_sfr | input | 8 | Port-2 register contents |
| code_hi | input | 8 | Upper byte of the fetch address |
| data_hi | input | 8 | Upper byte of the 16-bit data pointer |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| lo_latch | output | 1 | Low-address capture marker |
| p2_hi | output | 8 | Value on the high-address port |

## Verification
The test vectors cover every combination of internal and external execution, latch suppression set and clear, and idle, narrow-data, wide-data and code-table cycles. For each vector the bench records the exact clock counts of the strobe pulses.

The idle and data cycles separate which `ale` pulse is dropped. The suppressed cycles separate gating from override. The narrow and wide data cycles separate the three sources of `p2_hi`.

Directed cases check the reset values, sampling of a request present only at count 11, and a reset taken in the middle of a cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef struct packed {
    logic xdata;
    logic wide;
    logic movc;
  } cyc_t;

  localparam cyc_t CYC_IDLE = '{xdata: 1'b0, wide: 1'b0, movc: 1'b0};
endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/sbs_phase_ctr.sv
module sbs_phase_ctr #(
  parameter int N  = 12,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] ph_q,
  output logic [CW-1:0] ph_nxt,
  output logic          last
);
  localparam logic [CW-1:0] LAST_C = CW'(N - 1);

  assign last = (ph_q == LAST_C);

  always_comb begin
    if (last) ph_nxt = '0;
    else      ph_nxt = ph_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_nxt;
  end
endmodule

// File: rtl/sbs_cycle_reg.sv
module sbs_cycle_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  sbs_pkg::cyc_t   req,
  output sbs_pkg::cyc_t   cyc_q,
  output sbs_pkg::cyc_t   cyc_nxt
);
  always_comb begin
    cyc_nxt = cyc_q;
    if (load) cyc_nxt = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= sbs_pkg::CYC_IDLE;
    else        cyc_q <= cyc_nxt;
  end
endmodule

// File: rtl/sbs_strobe_gen.sv
module sbs_strobe_gen #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int CW     = $clog2(STATES * PHASES)
) (
  input  logic [CW-1:0]  ph,
  input  sbs_pkg::cyc_t  cyc,
  input  logic           ext_exec,
  input  logic           ale_off,
  output logic           ale_d,
  output logic           psen_n_d
);
  localparam int HALF = (STATES * PHASES) / 2;
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] PH_C   = CW'(PHASES);

  logic [CW-1:0] pos;
  logic          second, in_ale, in_psen, keep, gate;

  always_comb begin
    second   = (ph >= HALF_C);
    pos      = second ? (ph - HALF_C) : ph;
    in_ale   = (pos >= CW'(1)) && (pos <= PH_C);
    in_psen  = (pos > PH_C);
    // a data cycle gives up the first latch pulse of its machine cycle
    keep     = !(cyc.xdata && !second);
    gate     = !ale_off || ext_exec || cyc.xdata || cyc.movc;
    ale_d    = in_ale && keep && gate;
    psen_n_d = !(ext_exec && !cyc.xdata && in_psen);
  end
endmodule

// File: rtl/sbs_strobe_seq.sv
module sbs_strobe_seq #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_exec,
  input  logic          ale_off,
  input  logic          req_xdata,
  input  logic          req_wide,
  input  logic          req_movc,
  input  logic [AW-1:0] p2_sfr,
  input  logic [AW-1:0] code_hi,
  input  logic [AW-1:0] data_hi,
  output logic          ale,
  output logic          psen_n,
  output logic          lo_latch,
  output logic [AW-1:0] p2_hi
);
  localparam int N  = STATES * PHASES;
  localparam int CW = $clog2(N);

  logic          rst_sync_n;
  logic [CW-1:0] ph_q, ph_nxt;
  logic          last;
  sbs_pkg::cyc_t req, cyc_q, cyc_nxt;
  logic          ale_d, psen_n_d;
  logic          ale_q, psen_q, latch_q;
  logic [AW-1:0] p2_q, p2_d;

  sbs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sbs_phase_ctr #(.N(N), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .ph_q(ph_q), .ph_nxt(ph_nxt), .last(last)
  );

  assign req = '{xdata: req_xdata, wide: req_wide, movc: req_movc};

  sbs_cycle_reg u_cyc (
    .clk(clk), .rst_n(rst_sync_n), .load(last), .req(req),
    .cyc_q(cyc_q), .cyc_nxt(cyc_nxt)
  );

  sbs_strobe_gen #(.STATES(STATES), .PHASES(PHASES), .CW(CW)) u_gen (
    .ph(ph_nxt), .cyc(cyc_nxt), .ext_exec(ext_exec), .ale_off(ale_off),
    .ale_d(ale_d), .psen_n_d(psen_n_d)
  );

  always_comb begin
    if (req.xdata)    p2_d = req.wide ? data_hi : p2_sfr;
    else if (ext_exec) p2_d = code_hi;
    else               p2_d = p2_sfr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ale_q   <= 1'b0;
      psen_q  <= 1'b1;
      latch_q <= 1'b0;
      p2_q    <= '1;
    end else begin
      ale_q   <= ale_d;
      psen_q  <= psen_n_d;
      latch_q <= ale_q && !ale_d;
      if (last) p2_q <= p2_d;
    end
  end

  assign ale      = ale_q;
  assign psen_n   = psen_q;
  assign lo_latch = latch_q;
  assign p2_hi    = p2_q;
endmodule

// File: rtl/sbs_strobe_seq_chk.sv
module sbs_strobe_seq_chk #(
  parameter int CW = 4,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_i,
  input logic          ext_exec,
  input logic          ale_off,
  input logic          ale,
  input logic          psen_n,
  input logic          lo_latch,
  input logic [AW-1:0] p2_hi,
  input logic [CW-1:0] ph_q,
  input sbs_pkg::cyc_t cyc_q
);
  p_strobe_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_i)
    !(ale && !psen_n));

  p_psen_quiet_r7: assert property (@(posedge clk) disable iff (!rst_i)
    !$past(ext_exec) |-> psen_n);

  p_latch_edge_r9: assert property (@(posedge clk) disable iff (!rst_i)
    lo_latch == $fell(ale));

  p_p2_hold_r11: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q != '0) |-> $stable(p2_hi));

  p_ale_gate_r3: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(ale_off) && !$past(ext_exec) && !cyc_q.xdata && !cyc_q.movc) |-> !ale);
endmodule

bind sbs_strobe_seq sbs_strobe_seq_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_i(rst_sync_n), .ext_exec(ext_exec), .ale_off(ale_off),
  .ale(ale), .psen_n(psen_n), .lo_latch(lo_latch), .p2_hi(p2_hi),
  .ph_q(ph_q), .cyc_q(cyc_q)
);

// File: tb/sbs_strobe_seq_bench.sv
module sbs_strobe_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_exec, ale_off, req_xdata, req_wide, req_movc;
  logic [7:0] p2_sfr, code_hi, data_hi, p2_hi;
  logic ale, psen_n, lo_latch;

  localparam logic [7:0] SFR_V = 8'h5A, CODE_V = 8'hC3, DATA_V = 8'h81;

  sbs_strobe_seq u_sbs_strobe_seq (
    .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .ale_off(ale_off),
    .req_xdata(req_xdata), .req_wide(req_wide), .req_movc(req_movc),
    .p2_sfr(p2_sfr), .code_hi(code_hi), .data_hi(data_hi),
    .ale(ale), .psen_n(psen_n), .lo_latch(lo_latch), .p2_hi(p2_hi)
  );

  // {ext, off, xdata, wide, movc, ale pulses[2], psen pulses[2], p2 select[2]}
  // p2 select: 0 = port-2 register, 1 = fetch upper byte, 2 = pointer upper byte
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    {5'b00000, 2'd2, 2'd0, 2'd0},  // internal idle        R1 R7
    {5'b10000, 2'd2, 2'd2, 2'd1},  // external fetch       R5 R8
    {5'b00110, 2'd1, 2'd0, 2'd2},  // internal wide data   R2 R8
    {5'b00100, 2'd1, 2'd0, 2'd0},  // internal narrow data R2 R8
    {5'b10110, 2'd1, 2'd0, 2'd2},  // external wide data   R6
    {5'b10100, 2'd1, 2'd0, 2'd0},  // external narrow data R6
    {5'b01000, 2'd0, 2'd0, 2'd0},  // suppressed idle      R3
    {5'b01100, 2'd1, 2'd0, 2'd0},  // suppressed data      R3
    {5'b01001, 2'd2, 2'd0, 2'd0},  // suppressed table rd  R3
    {5'b11000, 2'd2, 2'd2, 2'd1},  // override             R4
    {5'b11100, 2'd1, 2'd0, 2'd0}   // override with data   R4
  };

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input string rq, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp_v);
    end
  endtask

  function automatic int ale_mask(input int n);
    return (n == 2) ? 'h186 : (n == 1) ? 'h180 : 0;
  endfunction

  function automatic int psen_mask(input int n);
    return (n == 2) ? 'hE38 : 0;
  endfunction

  function automatic int p2_exp(input int sel);
    return (sel == 2) ? DATA_V : (sel == 1) ? CODE_V : SFR_V;
  endfunction

  // one machine cycle: called at count 0 (negedge), returns at next count 0
  task automatic run_mc(output logic [11:0] am, output logic [11:0] pm,
                        output int ac, output int pc, output int lc,
                        output logic [7:0] p2s);
    logic pa, pp;
    am = '0; pm = '0; ac = 0; pc = 0; lc = 0; p2s = '0;
    pa = ale; pp = psen_n;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      am[(i + 1) % 12] = ale;
      pm[(i + 1) % 12] = !psen_n;
      if (ale && !pa) ac++;
      if (!psen_n && pp) pc++;
      if (lo_latch) lc++;
      if (i == 5) p2s = p2_hi;
      pa = ale; pp = psen_n;
    end
  endtask

  task automatic do_reset_release;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] am, pm;
    int ac, pc, lc;
    logic [7:0] p2s;
    rst_n = 1'b0; ext_exec = 0; ale_off = 0; req_xdata = 0; req_wide = 0;
    req_movc = 0; p2_sfr = SFR_V; code_hi = CODE_V; data_hi = DATA_V;
    repeat (3) @(negedge clk);
    chk("R10 reset ale", int'(ale), 0);
    chk("R10 reset psen_n", int'(psen_n), 1);
    chk("R10 reset lo_latch", int'(lo_latch), 0);
    chk("R10 reset p2_hi", int'(p2_hi), 'hFF);
    do_reset_release();

    for (int v = 0; v < NV; v++) begin
      {ext_exec, ale_off, req_xdata, req_wide, req_movc} = VEC[v][10:6];
      run_mc(am, pm, ac, pc, lc, p2s);  // settle
      run_mc(am, pm, ac, pc, lc, p2s);
      chk($sformatf("R1 R2 R3 R4 ale count v%0d", v), ac, int'(VEC[v][5:4]));
      chk($sformatf("R1 R2 ale clocks v%0d", v), int'(am), ale_mask(int'(VEC[v][5:4])));
      chk($sformatf("R5 R6 R7 psen count v%0d", v), pc, int'(VEC[v][3:2]));
      chk($sformatf("R5 psen clocks v%0d", v), int'(pm), psen_mask(int'(VEC[v][3:2])));
      chk($sformatf("R8 p2_hi v%0d", v), int'(p2s), p2_exp(int'(VEC[v][1:0])));
      chk($sformatf("R9 latch count v%0d", v), lc, ac);
    end

    // R10: a request present only at count 11 shapes the next cycle
    ext_exec = 0; ale_off = 0; req_xdata = 0; req_wide = 0; req_movc = 0;
    run_mc(am, pm, ac, pc, lc, p2s);
    repeat (11) begin @(posedge clk); @(negedge clk); end
    req_xdata = 1; req_wide = 1;
    @(posedge clk); @(negedge clk);
    req_xdata = 0; req_wide = 0;
    run_mc(am, pm, ac, pc, lc, p2s);
    chk("R10 count-11 request ale", ac, 1);
    chk("R10 count-11 request p2_hi", int'(p2s), DATA_V);

    // R10: reset in mid cycle
    ext_exec = 1;
    run_mc(am, pm, ac, pc, lc, p2s);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 mid reset ale", int'(ale), 0);
    chk("R10 mid reset psen_n", int'(psen_n), 1);
    chk("R10 mid reset p2_hi", int'(p2_hi), 'hFF);
    do_reset_release();
    run_mc(am, pm, ac, pc, lc, p2s);
    run_mc(am, pm, ac, pc, lc, p2s);
    chk("R1 after reset ale clocks", int'(am), 'h186);
    chk("R5 after reset psen clocks", int'(pm), 'hE38);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule